// File: doc/BRIEF.md
# Upstream Bus Detach and Reattach Configuration Register

This block is one 32-bit configuration and status word for a network device that hangs off an upstream serial bus. Software can set a control bit that drops the device off the upstream bus. The device then stays off the bus until it sees a wake event: a rising edge on the link-up indication or on a wake GPIO. The wake event puts the device back on the bus and raises a sticky flag. Software reads that flag after it reloads and clears it by writing a 1 to it.

The same word also holds several settings:
- the drive-strength boost level of the upstream transmitter;
- the answer given to a bulk IN request when the receive buffer is empty;
- a bypass that shortens the activity LED timing;
- a switch that selects emulated descriptor storage.

A protect bit keeps the emulation switch, the boost level and the protect bit itself through a soft reset. Only power-on reset clears them while the protect bit is set.

Access uses a simple register bus: an address, write data, a write strobe and combinational read data. Both resets are synchronous and active high.

Top module: `usb_detach_cfg`

## Requirements
- R1: A write to the register address with bit 17 set takes the device off the bus (bus_attach_o low) from the cycle after the write. While detached, bit 17 reads 1. It clears itself when the device reattaches.
- R2: Each wake input passes through two synchronising flops. Only a rising edge of the synchronised signal seen while detached counts as a wake event. The device stays detached until such an event, and edges seen while attached are ignored.
- R3: A wake event sets bus_attach_o high on the next clock edge and sets the detach status flag, bit 18.
- R4: The status flag is cleared by writing 1 to bit 18, and writing 0 to bit 18 leaves it unchanged. If a wake event and a clear happen in the same cycle, the set wins.
- R5: A write that sets bit 17 in the same cycle as a wake event keeps the device detached, and that event does not set the status flag.
- R6: Bits 14:13 hold the boost level, driven on boost_o: 00 normal, 01 +4%, 10 +8%, 11 +12%.
- R7: Bit 12 drives empty_nak_o. 0 answers an empty-buffer bulk IN with a zero-length packet, and 1 answers with a NAK.
- R8: Bit 11 drives led_fast_o. 1 shortens the LED on and off time from about 80 ms to about 15 µs.
- R9: Bit 16 drives eep_emul_o, which selects emulated descriptor storage when no EEPROM is present.
- R10: Bits 31:19 and 10:0 read as zero. Reads from any other address return zero, and writes to any other address change nothing.
- R11: Power-on reset clears every field and the wake synchronisers, and leaves the device attached.
- R12: Soft reset clears bits 12 and 11, the status flag, the detach state and the synchronisers. It clears bits 16, 15 and 14:13 only when bit 15 is 0. A write in the same cycle as a soft reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 32 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 32 | Register bus read data (combinational) |
| link_up_i | input | 1 | Asynchronous link-up indication (wake source) |
| gpio_wake_i | input | 1 | Asynchronous GPIO wake input |
| bus_attach_o | output | 1 | High while the device is attached to the upstream bus |
| boost_o | output | 2 | Upstream drive boost level |
| empty_nak_o | output | 1 | 1 = NAK, 0 = zero-length packet on empty bulk IN |
| led_fast_o | output | 1 | Activity LED short-timing bypass |
| eep_emul_o | output | 1 | Emulated descriptor storage select |

## Verification
The assertions assume that both resets are synchronous and are sampled only at a clock edge. They also assume that the register bus holds its address, data and strobe steady across each edge. The wake inputs may change at any time, because the properties look only at the synchronised edge and not at the raw pins.

The bench drives every input a short delay after the rising edge, so each value is stable when the next edge samples it. It also times one detach write to land exactly in the cycle where a synchronised wake edge is pending, which exercises the collision rule.

// File: rtl/usbdc_pkg.sv
package usbdc_pkg;

    localparam int WORD_W    = 32;
    localparam int BIT_STS   = 18;
    localparam int BIT_DET   = 17;
    localparam int BIT_EEM   = 16;
    localparam int BIT_PROT  = 15;
    localparam int BIT_BST_H = 14;
    localparam int BIT_BST_L = 13;
    localparam int BIT_NAK   = 12;
    localparam int BIT_LED   = 11;

    typedef enum logic [1:0] {
        BOOST_NORM = 2'b00,
        BOOST_P4   = 2'b01,
        BOOST_P8   = 2'b10,
        BOOST_P12  = 2'b11
    } boost_e;

    typedef enum logic {
        LINK_ATTACHED = 1'b0,
        LINK_DETACHED = 1'b1
    } attach_e;

    typedef struct packed {
        logic   eep_emul;
        logic   protect;
        boost_e boost;
    } prot_fields_t;

    typedef struct packed {
        logic empty_nak;
        logic led_fast;
    } plain_fields_t;

    function automatic logic [WORD_W-1:0] pack_word(
        prot_fields_t  p,
        plain_fields_t u,
        logic          detached,
        logic          status
    );
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[BIT_STS]             = status;
        w[BIT_DET]             = detached;
        w[BIT_EEM]             = p.eep_emul;
        w[BIT_PROT]            = p.protect;
        w[BIT_BST_H:BIT_BST_L] = p.boost;
        w[BIT_NAK]             = u.empty_nak;
        w[BIT_LED]             = u.led_fast;
        return w;
    endfunction

endpackage

// File: rtl/usbdc_wake_edge.sv
module usbdc_wake_edge #(
    parameter int N_WAKE      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [N_WAKE-1:0] wake_i,
    output logic [N_WAKE-1:0] rise_o
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    for (genvar g = 0; g < N_WAKE; g++) begin : g_lane
        logic [PIPE_W-1:0] pipe_q;

        always_ff @(posedge clk) begin
            if (clr) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[PIPE_W-2:0], wake_i[g]};
            end
        end

        // synchronised level is pipe_q[SYNC_STAGES-1], its previous value sits above it
        assign rise_o[g] = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
    end

endmodule

// File: rtl/usbdc_detach_fsm.sv
module usbdc_detach_fsm
    import usbdc_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic soft_rst,
    input  logic det_req,
    input  logic sts_clr,
    input  logic wake_any,
    output logic detached_o,
    output logic status_o,
    output logic wake_evt_o
);
    attach_e state_q;
    logic    status_q;

    assign detached_o = (state_q == LINK_DETACHED);
    assign wake_evt_o = detached_o & wake_any;
    assign status_o   = status_q;

    always_ff @(posedge clk) begin
        if (por || soft_rst) begin
            state_q  <= LINK_ATTACHED;
            status_q <= 1'b0;
        end else begin
            if (det_req) begin
                state_q <= LINK_DETACHED;
            end else if (wake_evt_o) begin
                state_q <= LINK_ATTACHED;
            end

            if (wake_evt_o && !det_req) begin
                status_q <= 1'b1;
            end else if (sts_clr) begin
                status_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usbdc_cfg_fields.sv
module usbdc_cfg_fields
    import usbdc_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output prot_fields_t      prot_o,
    output plain_fields_t     plain_o
);
    prot_fields_t  prot_q;
    plain_fields_t plain_q;

    always_ff @(posedge clk) begin
        if (por) begin
            prot_q  <= '0;
            plain_q <= '0;
        end else if (soft_rst) begin
            plain_q <= '0;
            if (!prot_q.protect) begin
                prot_q <= '0;
            end
        end else if (wr_en) begin
            prot_q.eep_emul   <= wdata[BIT_EEM];
            prot_q.protect    <= wdata[BIT_PROT];
            prot_q.boost      <= boost_e'(wdata[BIT_BST_H:BIT_BST_L]);
            plain_q.empty_nak <= wdata[BIT_NAK];
            plain_q.led_fast  <= wdata[BIT_LED];
        end
    end

    assign prot_o  = prot_q;
    assign plain_o = plain_q;

endmodule

// File: rtl/usb_detach_cfg.sv
module usb_detach_cfg
    import usbdc_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h14,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    input  logic              link_up_i,
    input  logic              gpio_wake_i,
    output logic              bus_attach_o,
    output logic [1:0]        boost_o,
    output logic              empty_nak_o,
    output logic              led_fast_o,
    output logic              eep_emul_o
);
    localparam int N_WAKE = 2;

    logic          addr_hit;
    logic          wr_hit;
    logic [N_WAKE-1:0] wake_rise;
    logic          detached;
    logic          status_q;
    logic          wake_evt;
    prot_fields_t  prot_q;
    plain_fields_t plain_q;

    assign addr_hit = (reg_addr == CFG_OFFSET);
    assign wr_hit   = reg_we & addr_hit;

    usbdc_wake_edge #(
        .N_WAKE      (N_WAKE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk    (clk),
        .clr    (por | soft_rst),
        .wake_i ({gpio_wake_i, link_up_i}),
        .rise_o (wake_rise)
    );

    usbdc_detach_fsm u_fsm (
        .clk        (clk),
        .por        (por),
        .soft_rst   (soft_rst),
        .det_req    (wr_hit & reg_wdata[BIT_DET]),
        .sts_clr    (wr_hit & reg_wdata[BIT_STS]),
        .wake_any   (|wake_rise),
        .detached_o (detached),
        .status_o   (status_q),
        .wake_evt_o (wake_evt)
    );

    usbdc_cfg_fields u_fields (
        .clk      (clk),
        .por      (por),
        .soft_rst (soft_rst),
        .wr_en    (wr_hit),
        .wdata    (reg_wdata),
        .prot_o   (prot_q),
        .plain_o  (plain_q)
    );

    assign reg_rdata    = addr_hit ? pack_word(prot_q, plain_q, detached, status_q) : '0;
    assign bus_attach_o = ~detached;
    assign boost_o      = prot_q.boost;
    assign empty_nak_o  = plain_q.empty_nak;
    assign led_fast_o   = plain_q.led_fast;
    assign eep_emul_o   = prot_q.eep_emul;

endmodule

// File: rtl/usb_detach_cfg_chk.sv
module usb_detach_cfg_chk (
    input logic        clk,
    input logic        por,
    input logic        soft_rst,
    input logic        wr_hit,
    input logic [31:0] reg_wdata,
    input logic        wake_evt,
    input logic        bus_attach_o,
    input logic        status,
    input logic        protect,
    input logic [1:0]  boost_o,
    input logic [31:0] reg_rdata
);
    p_detach_r1: assert property (@(posedge clk) disable iff (por)
        (wr_hit && reg_wdata[17] && !soft_rst) |=> !bus_attach_o);

    p_hold_r2: assert property (@(posedge clk) disable iff (por)
        (!bus_attach_o && !wake_evt && !soft_rst) |=> !bus_attach_o);

    p_wake_r3: assert property (@(posedge clk) disable iff (por)
        (wake_evt && !(wr_hit && reg_wdata[17]) && !soft_rst) |=> (bus_attach_o && status));

    p_w1c_r4: assert property (@(posedge clk) disable iff (por)
        (wr_hit && reg_wdata[18] && !wake_evt && !soft_rst) |=> !status);

    p_collide_r5: assert property (@(posedge clk) disable iff (por)
        (wr_hit && reg_wdata[17] && wake_evt && !soft_rst) |=> (!bus_attach_o && !$rose(status)));

    p_reserved_r10: assert property (@(posedge clk) disable iff (por)
        (reg_rdata[31:19] == 13'd0) && (reg_rdata[10:0] == 11'd0));

    p_protect_r12: assert property (@(posedge clk) disable iff (por)
        (soft_rst && protect) |=> $stable(boost_o));

endmodule

bind usb_detach_cfg usb_detach_cfg_chk u_chk (
    .clk          (clk),
    .por          (por),
    .soft_rst     (soft_rst),
    .wr_hit       (wr_hit),
    .reg_wdata    (reg_wdata),
    .wake_evt     (wake_evt),
    .bus_attach_o (bus_attach_o),
    .status       (status_q),
    .protect      (prot_q.protect),
    .boost_o      (boost_o),
    .reg_rdata    (reg_rdata)
);

// File: tb/usb_detach_cfg_tb_top.sv
module usb_detach_cfg_tb_top;
    localparam logic [7:0] REG = 8'h14;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        soft_rst = 1'b0;
    logic [7:0]  reg_addr = REG;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        link_up_i = 1'b0;
    logic        gpio_wake_i = 1'b0;
    logic        bus_attach_o;
    logic [1:0]  boost_o;
    logic        empty_nak_o;
    logic        led_fast_o;
    logic        eep_emul_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_detach_cfg dut_i (
        .clk          (clk),
        .por          (por),
        .soft_rst     (soft_rst),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_rdata    (reg_rdata),
        .link_up_i    (link_up_i),
        .gpio_wake_i  (gpio_wake_i),
        .bus_attach_o (bus_attach_o),
        .boost_o      (boost_o),
        .empty_nak_o  (empty_nak_o),
        .led_fast_o   (led_fast_o),
        .eep_emul_o   (eep_emul_o)
    );

    // behavioural reference state
    bit       m_det, m_sts, m_eem, m_prot, m_nak, m_led, m_ready;
    bit [1:0] m_bst;
    bit       m_s1 [2];
    bit       m_s2 [2];
    bit       m_pv [2];

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[18] = m_sts; w[17] = m_det; w[16] = m_eem; w[15] = m_prot;
        w[14:13] = m_bst; w[12] = m_nak; w[11] = m_led;
        return w;
    endfunction

    always @(posedge clk) begin
        bit wake_in [2];
        bit evt, wr, det_wr;
        wake_in[0] = link_up_i;
        wake_in[1] = gpio_wake_i;
        m_ready = 1'b1;
        if (por) begin
            m_det = 0; m_sts = 0; m_eem = 0; m_prot = 0; m_bst = 0; m_nak = 0; m_led = 0;
            for (int i = 0; i < 2; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; end
        end else if (soft_rst) begin
            m_det = 0; m_sts = 0; m_nak = 0; m_led = 0;
            if (!m_prot) begin m_eem = 0; m_bst = 0; end
            for (int i = 0; i < 2; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; end
        end else begin
            evt = 0;
            for (int i = 0; i < 2; i++) if (m_s2[i] && !m_pv[i]) evt = m_det;
            wr = reg_we && (reg_addr == REG);
            det_wr = wr && reg_wdata[17];
            if (det_wr) m_det = 1;
            else if (evt) m_det = 0;
            if (evt && !det_wr) m_sts = 1;
            else if (wr && reg_wdata[18]) m_sts = 0;
            if (wr) begin
                m_eem = reg_wdata[16]; m_prot = reg_wdata[15]; m_bst = reg_wdata[14:13];
                m_nak = reg_wdata[12]; m_led = reg_wdata[11];
            end
            for (int i = 0; i < 2; i++) begin
                m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = wake_in[i];
            end
        end
        // protect bit itself clears on soft reset only when it was 0 (already 0)
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (m_ready && !done) begin
            chk("R2 attach", {31'd0, bus_attach_o}, {31'd0, !m_det});
            chk("R6 boost", {30'd0, boost_o}, {30'd0, m_bst});
            chk("R7 nak", {31'd0, empty_nak_o}, {31'd0, m_nak});
            chk("R8 led", {31'd0, led_fast_o}, {31'd0, m_led});
            chk("R9 eem", {31'd0, eep_emul_o}, {31'd0, m_eem});
            chk("R10 rdata", reg_rdata, (reg_addr == REG) ? model_word() : 32'd0);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0; reg_addr = REG; reg_wdata = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        por = 1'b0;
        step();
        #5;
        chk("R11 reset word", reg_rdata, 32'd0);
        chk("R11 reset attach", {31'd0, bus_attach_o}, 32'd1);

        // fields: eem=1 prot=0 boost=10 nak=1 led=1, plus reserved bits set
        wr(REG, 32'hFFF8_07FF | (32'd1 << 16) | (32'd2 << 13) | (32'd1 << 12) | (32'd1 << 11));
        #5;
        chk("R6 boost +8", {30'd0, boost_o}, 32'd2);
        chk("R7 nak", {31'd0, empty_nak_o}, 32'd1);
        chk("R8 led", {31'd0, led_fast_o}, 32'd1);
        chk("R9 eem", {31'd0, eep_emul_o}, 32'd1);
        chk("R10 reserved", reg_rdata & 32'hFFF8_07FF, 32'd0);

        // write to another address is ignored; read there is zero
        wr(8'h18, 32'h0000_0000);
        #5;
        chk("R10 foreign write", {30'd0, boost_o}, 32'd2);
        reg_addr = 8'h18; #1;
        chk("R10 foreign read", reg_rdata, 32'd0);
        reg_addr = REG;
        step();

        // detach, then link-up wake
        wr(REG, 32'd1 << 17);
        #5;
        chk("R1 detached", {31'd0, bus_attach_o}, 32'd0);
        chk("R1 readback", {31'd0, reg_rdata[17]}, 32'd1);
        step(5);
        chk("R2 stays off", {31'd0, bus_attach_o}, 32'd0);
        link_up_i = 1'b1;
        step(4);
        chk("R3 reattach", {31'd0, bus_attach_o}, 32'd1);
        chk("R3 status", {31'd0, reg_rdata[18]}, 32'd1);
        chk("R1 self clear", {31'd0, reg_rdata[17]}, 32'd0);

        // edges while attached do nothing
        gpio_wake_i = 1'b1; step(4); gpio_wake_i = 1'b0; step(4);
        chk("R2 attached edge", {31'd0, bus_attach_o}, 32'd1);
        wr(REG, 32'd0);
        #5;
        chk("R4 write zero", {31'd0, reg_rdata[18]}, 32'd1);
        wr(REG, 32'd1 << 18);
        #5;
        chk("R4 w1c", {31'd0, reg_rdata[18]}, 32'd0);
        link_up_i = 1'b0;
        step(4);

        // gpio wake
        wr(REG, 32'd1 << 17);
        gpio_wake_i = 1'b1;
        step(4);
        chk("R3 gpio wake", {31'd0, bus_attach_o}, 32'd1);
        gpio_wake_i = 1'b0;
        wr(REG, 32'd1 << 18);
        step(3);

        // collision: detach write in the cycle the synchronised edge is pending (R5)
        wr(REG, 32'd1 << 17);
        link_up_i = 1'b1;
        step(2);
        wr(REG, 32'd1 << 17);
        #5;
        chk("R5 detach wins", {31'd0, bus_attach_o}, 32'd0);
        chk("R5 no status", {31'd0, reg_rdata[18]}, 32'd0);
        link_up_i = 1'b0; step(4);
        link_up_i = 1'b1; step(4);
        chk("R3 later wake", {31'd0, bus_attach_o}, 32'd1);
        link_up_i = 1'b0; step(3);

        // soft reset, protect off
        wr(REG, (32'd1 << 16) | (32'd3 << 13) | (32'd1 << 12));
        soft_rst = 1'b1; reg_we = 1'b1; reg_wdata = 32'd1 << 11;
        step();
        soft_rst = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        #5;
        chk("R12 unprotected boost", {30'd0, boost_o}, 32'd0);
        chk("R12 nak cleared", {31'd0, empty_nak_o}, 32'd0);
        chk("R12 write ignored", {31'd0, led_fast_o}, 32'd0);

        // soft reset, protect on
        wr(REG, (32'd1 << 16) | (32'd1 << 15) | (32'd1 << 13) | (32'd1 << 11));
        wr(REG, (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 15) | (32'd1 << 13) | (32'd1 << 11));
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        #5;
        chk("R12 boost kept", {30'd0, boost_o}, 32'd1);
        chk("R12 eem kept", {31'd0, eep_emul_o}, 32'd1);
        chk("R12 protect kept", {31'd0, reg_rdata[15]}, 32'd1);
        chk("R12 led cleared", {31'd0, led_fast_o}, 32'd0);
        chk("R12 reattached", {31'd0, bus_attach_o}, 32'd1);

        // power-on reset clears protected fields too
        por = 1'b1; step(); por = 1'b0;
        #5;
        chk("R11 por word", reg_rdata, 32'd0);
        chk("R11 por boost", {30'd0, boost_o}, 32'd0);
        step(2);
        finish_run();
    end

endmodule